// File: doc/BRIEF.md
# Serial EEPROM Write-Protect and Status Unit

This unit sits beside the command decoder of a serial EEPROM slave. It decides whether a memory write may proceed and produces the status byte that a status-read command shifts out. It holds three pieces of state:

- a write-enable latch;
- a two-bit block-protect level;
- a busy timer that stands in for the internal programming cycle.

The command decoder gives it one-cycle strobes: set-enable, clear-enable, write-status (carrying the new protect bits) and write-request (carrying the target address). It also sees the level of the external write-protect pin. For each write request the unit answers in the same cycle with a permit flag. An accepted write, whether to memory or to the status bits, starts the busy timer. When the timer expires, the enable latch drops, so every programming operation needs a fresh set-enable first. Retention across power loss is not modelled, and the protect bits reset to zero.

Top module: `eewp_status_unit`

## Requirements
- R1: After reset `stat_byte_o` is 8'h00 and `busy_o` is 0 (latch clear, protect level 00, idle).
- R2: While idle, `stat_byte_o` has bits 7..4 = 0, bits 3..2 = protect level (bit 3 high-order), bit 1 = enable latch, bit 0 = 0.
- R3: An accepted write raises `busy_o` from the next cycle for exactly `WRITE_CYCLES` cycles, and `stat_byte_o` reads 8'hFF throughout.
- R4: A set-enable strobe sets the latch only when `wp_pin_i` is 1. With the pin at 0 the latch is unchanged.
- R5: A clear-enable strobe clears the latch whatever the pin level. Clear wins over a set-enable in the same cycle.
- R6: `wr_permit_o` is combinational and is 1 only when `mem_wr_i` is 1, the latch is set, the unit is idle and the address is unprotected. A write that is not permitted starts no busy cycle. `wr_start_o` pulses in the cycle a write (memory or status) is accepted.
- R7: Protect level 00 guards nothing. Level 01 guards addresses whose two top bits are 11 (upper quarter). Level 10 guards addresses whose top bit is 1 (upper half). Level 11 guards every address.
- R8: A write-status strobe with the latch set and the unit idle loads the protect level from `stat_wdata_i[3:2]` and starts a busy cycle. With the latch clear it is discarded.
- R9: The enable latch is clear once a busy cycle ends.
- R10: Set-enable, clear-enable, write-status and write-request strobes that arrive while busy are discarded.
- R11: A write-status strobe in the same cycle as `mem_wr_i` is discarded; the memory write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin_i | input | 1 | Level of the external write-protect pin |
| en_set_i | input | 1 | Set-enable strobe |
| en_clr_i | input | 1 | Clear-enable strobe |
| stat_wr_i | input | 1 | Write-status strobe |
| stat_wdata_i | input | 8 | Status write data; bits 3..2 carry the new protect level |
| mem_wr_i | input | 1 | Memory write request strobe |
| mem_addr_i | input | ADDR_W | Address of the write request |
| wr_permit_o | output | 1 | Memory write accepted this cycle |
| wr_start_o | output | 1 | Any write accepted this cycle; busy cycle begins |
| busy_o | output | 1 | Internal write cycle in progress |
| stat_byte_o | output | 8 | Status byte for a status read |

## Verification
The hardest condition to reach is a strobe landing during a busy cycle whose effect would still be visible after the cycle ends. The latch is cleared at completion anyway, so set-enable and clear-enable during busy leave little to observe. The bench therefore sets the latch, starts a memory write, and then, while busy, issues a write-status with protect level 11 and a set-enable. After completion it checks that the level is still 00 and the latch is still clear. The protect boundaries are reached by first committing each level through a timed status write, then probing the permit flag on the addresses just below and at each boundary.

// File: rtl/eewp_pkg.sv
`timescale 1ns/1ps
package eewp_pkg;
   localparam int STAT_W = 8;

   typedef enum logic [1:0] {
      PROT_NONE = 2'b00,
      PROT_QTR  = 2'b01,
      PROT_HALF = 2'b10,
      PROT_ALL  = 2'b11
   } prot_lvl_e;

   function automatic logic [STAT_W-1:0] compose_status(
      input logic      busy,
      input prot_lvl_e lvl,
      input logic      wen
   );
      if (busy) return '1;
      return {4'b0000, lvl, wen, 1'b0};
   endfunction
endpackage

// File: rtl/eewp_busy_timer.sv
`timescale 1ns/1ps
module eewp_busy_timer #(
   parameter int CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start_i)
         cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/eewp_enable_latch.sv
`timescale 1ns/1ps
module eewp_enable_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic done_i,
   input  logic set_i,
   input  logic clr_i,
   input  logic wp_pin_i,
   output logic wen_o
);
   logic wen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wen_q <= 1'b0;
      else if (busy_i) begin
         if (done_i) wen_q <= 1'b0;
      end else if (clr_i)
         wen_q <= 1'b0;
      else if (set_i && wp_pin_i)
         wen_q <= 1'b1;
   end

   assign wen_o = wen_q;
endmodule

// File: rtl/eewp_protect_decode.sv
`timescale 1ns/1ps
module eewp_protect_decode
   import eewp_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  prot_lvl_e         lvl_i,
   output logic              guarded_o
);
   localparam int TOP = ADDR_W - 1;

   logic upper_half;
   logic upper_qtr;

   assign upper_half = addr_i[TOP];
   assign upper_qtr  = addr_i[TOP] & addr_i[TOP-1];

   always_comb begin
      unique case (lvl_i)
         PROT_NONE: guarded_o = 1'b0;
         PROT_QTR:  guarded_o = upper_qtr;
         PROT_HALF: guarded_o = upper_half;
         default:   guarded_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/eewp_status_unit.sv
`timescale 1ns/1ps
module eewp_status_unit
   import eewp_pkg::*;
#(
   parameter int ADDR_W       = 9,
   parameter int WRITE_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_pin_i,
   input  logic              en_set_i,
   input  logic              en_clr_i,
   input  logic              stat_wr_i,
   input  logic [7:0]        stat_wdata_i,
   input  logic              mem_wr_i,
   input  logic [ADDR_W-1:0] mem_addr_i,
   output logic              wr_permit_o,
   output logic              wr_start_o,
   output logic              busy_o,
   output logic [7:0]        stat_byte_o
);
   localparam int BP_LSB = 2;
   localparam int BP_MSB = BP_LSB + 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("eewp_status_unit: ADDR_W must be at least 2");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_cycles
         $error("eewp_status_unit: WRITE_CYCLES must be at least 1");
      end
   endgenerate

   logic      busy;
   logic      done;
   logic      wen;
   logic      guarded;
   logic      take_mem;
   logic      take_stat;
   prot_lvl_e lvl_q;

   eewp_protect_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i    (mem_addr_i),
      .lvl_i     (lvl_q),
      .guarded_o (guarded)
   );

   assign take_mem  = mem_wr_i & wen & ~busy & ~guarded;
   assign take_stat = stat_wr_i & ~mem_wr_i & wen & ~busy;

   eewp_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (take_mem | take_stat),
      .busy_o  (busy),
      .done_o  (done)
   );

   eewp_enable_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy_i   (busy),
      .done_i   (done),
      .set_i    (en_set_i),
      .clr_i    (en_clr_i),
      .wp_pin_i (wp_pin_i),
      .wen_o    (wen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_q <= PROT_NONE;
      else if (take_stat)
         lvl_q <= prot_lvl_e'(stat_wdata_i[BP_MSB:BP_LSB]);
   end

   assign wr_permit_o = take_mem;
   assign wr_start_o  = take_mem | take_stat;
   assign busy_o      = busy;
   assign stat_byte_o = compose_status(busy, lvl_q, wen);
endmodule

// File: rtl/eewp_status_chk.sv
`timescale 1ns/1ps
module eewp_status_chk #(
   parameter int ADDR_W       = 9,
   parameter int WRITE_CYCLES = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wp_pin_i,
   input logic              en_set_i,
   input logic              en_clr_i,
   input logic              stat_wr_i,
   input logic              mem_wr_i,
   input logic [ADDR_W-1:0] mem_addr_i,
   input logic              wr_permit_o,
   input logic              wr_start_o,
   input logic              busy_o,
   input logic [7:0]        stat_byte_o
);
   int run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_cnt <= 0;
      else        run_cnt <= busy_o ? run_cnt + 1 : 0;
   end

   AST_IDLE_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (stat_byte_o[7:4] == 4'h0 && !stat_byte_o[0])); // R2
   AST_BUSY_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> stat_byte_o == 8'hFF); // R3
   AST_START_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |=> busy_o); // R3
   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> run_cnt == WRITE_CYCLES); // R3
   AST_SET_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !stat_byte_o[1] && en_set_i && !wp_pin_i) |=> !stat_byte_o[1]); // R4
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && en_clr_i && !wr_start_o) |=> !stat_byte_o[1]); // R5
   AST_NO_PERMIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !stat_byte_o[1]) |-> (!wr_start_o && !wr_permit_o)); // R6
   AST_PERMIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit_o |-> mem_wr_i); // R6
   AST_ALL_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && stat_byte_o[3:2] == 2'b11) |-> !wr_permit_o); // R7
   AST_LATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !stat_byte_o[1]); // R9
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (!wr_start_o && !wr_permit_o)); // R10
   AST_STAT_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_i && mem_wr_i && !wr_permit_o) |-> !wr_start_o); // R11
endmodule

bind eewp_status_unit eewp_status_chk #(
   .ADDR_W       (ADDR_W),
   .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wp_pin_i    (wp_pin_i),
   .en_set_i    (en_set_i),
   .en_clr_i    (en_clr_i),
   .stat_wr_i   (stat_wr_i),
   .mem_wr_i    (mem_wr_i),
   .mem_addr_i  (mem_addr_i),
   .wr_permit_o (wr_permit_o),
   .wr_start_o  (wr_start_o),
   .busy_o      (busy_o),
   .stat_byte_o (stat_byte_o)
);

// File: tb/eewp_status_unit_bench.sv
`timescale 1ns/1ps
module eewp_status_unit_bench;
   localparam int AW  = 9;
   localparam int WCY = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_pin = 1'b1;
   logic          en_set = 1'b0;
   logic          en_clr = 1'b0;
   logic          stat_wr = 1'b0;
   logic [7:0]    stat_wdata = 8'h00;
   logic          mem_wr = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic          wr_permit;
   logic          wr_start;
   logic          busy;
   logic [7:0]    stat_byte;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   eewp_status_unit #(.ADDR_W(AW), .WRITE_CYCLES(WCY)) u_eewp_status_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .wp_pin_i     (wp_pin),
      .en_set_i     (en_set),
      .en_clr_i     (en_clr),
      .stat_wr_i    (stat_wr),
      .stat_wdata_i (stat_wdata),
      .mem_wr_i     (mem_wr),
      .mem_addr_i   (mem_addr),
      .wr_permit_o  (wr_permit),
      .wr_start_o   (wr_start),
      .busy_o       (busy),
      .stat_byte_o  (stat_byte)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h, expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      en_set = 0; en_clr = 0; stat_wr = 0; mem_wr = 0;
   endtask

   // counts busy cycles after a strobe was driven this cycle
   task automatic wait_done(input string req);
      int len = 0;
      step();
      idle_inputs();
      while (busy && len < WCY + 5) begin
         check(req, stat_byte, 8'hFF);
         len++;
         step();
      end
      check(req, len, WCY);
   endtask

   task automatic do_set();
      en_set = 1; step(); idle_inputs();
   endtask

   task automatic set_level(input logic [1:0] lvl);
      do_set();
      stat_wr = 1; stat_wdata = {4'h0, lvl, 2'b00};
      #1 check("R8 status write start", wr_start, 1);
      wait_done("R8 status write cycle");
      check("R8 level loaded, R9 latch clear", stat_byte, {4'h0, lvl, 2'b00});
   endtask

   task automatic probe(input string req, input logic [AW-1:0] a, input logic exp);
      mem_wr = 1; mem_addr = a;
      #1 check(req, wr_permit, exp);
      mem_wr = 0;
      #1;
   endtask

   task automatic t_reset();
      check("R1 status after reset", stat_byte, 8'h00);
      check("R1 busy after reset", busy, 0);
   endtask

   task automatic t_set_pin();
      wp_pin = 0; en_set = 1; step(); idle_inputs();
      check("R4 set ignored with pin low", stat_byte, 8'h00);
      wp_pin = 1; do_set();
      check("R4 R2 set with pin high", stat_byte, 8'h02);
   endtask

   task automatic t_clear();
      wp_pin = 0; en_clr = 1; step(); idle_inputs();
      check("R5 clear with pin low", stat_byte, 8'h00);
      wp_pin = 1; do_set();
      en_set = 1; en_clr = 1; step(); idle_inputs();
      check("R5 clear beats set", stat_byte, 8'h00);
   endtask

   task automatic t_write_disabled();
      mem_wr = 1; mem_addr = 9'h005; stat_wr = 1; stat_wdata = 8'h0C;
      #1 check("R6 no permit with latch clear", wr_permit, 0);
      check("R8 no start with latch clear", wr_start, 0);
      step(); idle_inputs();
      check("R6 R8 no busy cycle", stat_byte, 8'h00);
   endtask

   task automatic t_mem_write();
      do_set();
      mem_wr = 1; mem_addr = 9'h005;
      #1 check("R6 permit", wr_permit, 1);
      check("R6 start pulse", wr_start, 1);
      wait_done("R3 memory write cycle");
      check("R9 latch cleared at end", stat_byte, 8'h00);
   endtask

   task automatic t_busy_ignore();
      do_set();
      mem_wr = 1; mem_addr = 9'h010;
      step(); idle_inputs();
      check("R3 busy reads FF", stat_byte, 8'hFF);
      stat_wr = 1; stat_wdata = 8'h0C;
      #1 check("R10 status write ignored when busy", wr_start, 0);
      step(); idle_inputs();
      mem_wr = 1; mem_addr = 9'h011;
      #1 check("R10 write request ignored when busy", wr_permit, 0);
      step(); idle_inputs();
      en_set = 1; step(); idle_inputs();
      while (busy) step();
      check("R10 level and latch unchanged", stat_byte, 8'h00);
   endtask

   task automatic t_precedence();
      do_set();
      mem_wr = 1; mem_addr = 9'h000; stat_wr = 1; stat_wdata = 8'h0C;
      #1 check("R11 memory write wins", wr_permit, 1);
      wait_done("R11 single busy cycle");
      check("R11 level not loaded", stat_byte, 8'h00);
   endtask

   task automatic t_protect();
      do_set();
      probe("R7 level 00 top address open", 9'h1FF, 1);
      en_clr = 1; step(); idle_inputs();
      set_level(2'b01);
      do_set();
      probe("R7 level 01 below quarter", 9'h17F, 1);
      probe("R7 level 01 quarter start", 9'h180, 0);
      mem_wr = 1; mem_addr = 9'h1C0; step(); idle_inputs();
      check("R6 guarded write starts no cycle", stat_byte, 8'h06);
      en_clr = 1; step(); idle_inputs();
      set_level(2'b10);
      do_set();
      probe("R7 level 10 below half", 9'h0FF, 1);
      probe("R7 level 10 half start", 9'h100, 0);
      en_clr = 1; step(); idle_inputs();
      set_level(2'b11);
      do_set();
      probe("R7 level 11 address zero", 9'h000, 0);
      check("R2 idle layout level 11", stat_byte, 8'h0E);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_set_pin();
      t_clear();
      t_write_disabled();
      t_mem_write();
      t_busy_ignore();
      t_precedence();
      t_protect();
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule